// File: doc/BRIEF.md
# Ordered Store Buffer Bank with Shared Packet Port

This block sits between a group of cores and one interconnect injection port and reproduces the store ordering of a total-store-order memory model. Every core owns a private first-in first-out buffer of posted stores. A store from a core is taken into its buffer and creates no traffic on the interconnect. Traffic appears only when a read must be issued, when a buffer has to make room, or when software asks for a buffer to be emptied.

A read from a core is compared against the addresses held in that core's buffer. With no match, the read packet goes out at once. With a match, the buffer releases its stores oldest first as write packets until no entry with that address is left, and only then sends the read. Younger stores stay in the buffer. A core learns that its read has left through a one-cycle acknowledge. Read data comes back on a separate path that this block does not carry. Each core also has a flush pulse that empties its whole buffer, and a flag that reads high while its buffer is empty. A rotating-priority arbiter decides which core uses the shared valid/ready output.

Top module: `tso_sbuf`

## Requirements
- R1: After reset no packet is offered, every core's empty flag is high, every core's write-ready is high and no read acknowledge is raised.
- R2: A store from a core whose buffer has a free slot is accepted in the cycle its write-ready is high and produces no packet.
- R3: A read whose address matches no buffered entry of that core is offered in the same cycle as a packet with pkt_write = 0, the read address and zero data. The core's acknowledge is high for exactly the one cycle in which that packet is taken (pkt_valid and pkt_ready high). At most one acknowledge is high in any cycle.
- R4: A read whose address matches buffered entries makes the core offer write packets (pkt_write = 1) carrying the buffered address and data, until the youngest matching entry has left. Only after that does it offer the read packet. Entries younger than the youngest match stay in the buffer.
- R5: Stores always leave a buffer in the order in which they were accepted, oldest first.
- R6: A store to a full buffer is held: write-ready stays low and the oldest entry is offered as a write packet. The store is accepted in the cycle after that entry has been taken.
- R7: A flush pulse makes the core drain every buffered entry as write packets. From the pulse until the buffer is empty, write-ready is low. A flush of an empty buffer has no effect.
- R8: When several cores offer packets, the grant rotates: the search starts at the core after the one most recently granted and takes the first core that offers, with cores numbered upward and wrapping from the highest to 0. The core number appears on pkt_core.
- R9: While pkt_valid is high and pkt_ready is low, the offered packet (core, kind and address) stays unchanged in the next cycle.
- R10: A pending read takes priority over a store from the same core: while the core's read-valid is high, its write-ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_valid | input | NCORES | Per-core store request, held until write-ready |
| core_rd_valid | input | NCORES | Per-core read request, held until acknowledge |
| core_flush | input | NCORES | Per-core one-cycle flush pulse |
| core_addr | input | NCORES*AW | Per-core address for read or store, core c at bits c*AW upward |
| core_wdata | input | NCORES*DW | Per-core store data, core c at bits c*DW upward |
| core_wr_ready | output | NCORES | Per-core store accept |
| core_rd_ack | output | NCORES | Per-core one-cycle read-issued pulse |
| core_drained | output | NCORES | Per-core buffer empty flag |
| pkt_valid | output | 1 | Packet offered to the interconnect |
| pkt_ready | input | 1 | Interconnect takes the packet |
| pkt_write | output | 1 | 1 = write packet, 0 = read packet |
| pkt_addr | output | AW | Packet address |
| pkt_data | output | DW | Store data, zero for reads |
| pkt_core | output | CW | Number of the core owning the packet |

## Verification
Everything at the packet port responds combinationally to the current buffer state and the current core inputs. A read miss is therefore offered in the cycle its request is seen, and its acknowledge appears in the cycle the interconnect takes it. Store acceptance, draining of an entry and the empty flag take effect one clock edge after the cycle that caused them. The bench drives inputs just after a rising edge and compares every output against a queue-based model at the falling edge, so each cycle's expectation comes from the state built up to the previous edge. Throughout, stalls on pkt_ready exercise the hold and rotation rules.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  typedef enum logic {
    PKT_RD = 1'b0,
    PKT_WR = 1'b1
  } pkt_kind_e;
endpackage

// File: rtl/tso_sb_lane.sv
// One core's ordered store buffer and request generation.
module tso_sb_lane
  import tso_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          rd_valid,
  input  logic          flush,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          grant,
  output logic          wr_ready,
  output logic          drained,
  output logic          rd_done,
  output logic          req_valid,
  output pkt_kind_e     req_kind,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];
  logic [DEPTH-1:0] slot_v_q, slot_v_d;
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          fl_pend_q, fl_pend_d;
  logic          hit, full, empty, flushing, push, pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // address match against every occupied slot
  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (slot_v_q[j] && (slot_addr[j] == addr)) hit = 1'b1;
    end
  end

  always_comb begin
    full     = (cnt_q == NW'(DEPTH));
    empty    = (cnt_q == '0);
    flushing = fl_pend_q | flush;
    req_valid = 1'b0;
    req_kind  = PKT_WR;
    req_addr  = slot_addr[head_q];
    req_data  = slot_data[head_q];
    if (rd_valid) begin
      req_valid = 1'b1;
      if (!hit) begin
        req_kind = PKT_RD;
        req_addr = addr;
        req_data = '0;
      end
    end else if ((flushing || (wr_valid && full)) && !empty) begin
      req_valid = 1'b1;
    end
    wr_ready = !rd_valid && !flushing && !full;
    drained  = empty;
    push     = wr_valid && wr_ready;
    pop      = grant && (req_kind == PKT_WR);
    rd_done  = grant && (req_kind == PKT_RD);
  end

  // next-state
  always_comb begin
    slot_v_d = slot_v_q;
    head_d   = head_q;
    tail_d   = tail_q;
    cnt_d    = cnt_q;
    if (pop) begin
      slot_v_d[head_q] = 1'b0;
      head_d = ptr_inc(head_q);
    end
    if (push) begin
      slot_v_d[tail_q] = 1'b1;
      tail_d = ptr_inc(tail_q);
    end
    cnt_d = cnt_q + NW'(push) - NW'(pop);
    fl_pend_d = flushing && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v_q  <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
      fl_pend_q <= 1'b0;
    end else begin
      slot_v_q  <= slot_v_d;
      head_q    <= head_d;
      tail_q    <= tail_d;
      cnt_q     <= cnt_d;
      fl_pend_q <= fl_pend_d;
    end
  end

  // payload storage, no reset, written under enable
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail_q] <= addr;
      slot_data[tail_q] <= wdata;
    end
  end
endmodule

// File: rtl/tso_sb_rr.sv
// Rotating-priority choice with a lock that holds the winner under backpressure.
module tso_sb_rr #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ready,
  output logic          any,
  output logic [CW-1:0] win,
  output logic [N-1:0]  gnt
);
  logic [CW-1:0] ptr_q, ptr_d, lock_idx_q, lock_idx_d;
  logic          lock_q, lock_d;
  logic [CW-1:0] scan_win;
  logic          found;

  always_comb begin
    found    = 1'b0;
    scan_win = ptr_q;
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(ptr_q) + i;
      if (k >= N) k = k - N;
      if (!found && req[k]) begin
        found    = 1'b1;
        scan_win = CW'(k);
      end
    end
    any = |req;
    win = (lock_q && req[lock_idx_q]) ? lock_idx_q : scan_win;
    gnt = '0;
    if (any && ready) gnt[win] = 1'b1;
  end

  always_comb begin
    ptr_d      = ptr_q;
    lock_d     = lock_q;
    lock_idx_d = lock_idx_q;
    if (any && ready) begin
      ptr_d  = (win == CW'(N - 1)) ? '0 : win + 1'b1;
      lock_d = 1'b0;
    end else if (any) begin
      lock_d     = 1'b1;
      lock_idx_d = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      ptr_q      <= ptr_d;
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
    end
  end
endmodule

// File: rtl/tso_sbuf.sv
module tso_sbuf
  import tso_sb_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int DEPTH  = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    core_wr_valid,
  input  logic [NCORES-1:0]    core_rd_valid,
  input  logic [NCORES-1:0]    core_flush,
  input  logic [NCORES*AW-1:0] core_addr,
  input  logic [NCORES*DW-1:0] core_wdata,
  output logic [NCORES-1:0]    core_wr_ready,
  output logic [NCORES-1:0]    core_rd_ack,
  output logic [NCORES-1:0]    core_drained,
  output logic                 pkt_valid,
  input  logic                 pkt_ready,
  output logic                 pkt_write,
  output logic [AW-1:0]        pkt_addr,
  output logic [DW-1:0]        pkt_data,
  output logic [CW-1:0]        pkt_core
);
  logic [NCORES-1:0] lane_req, lane_gnt;
  pkt_kind_e         lane_kind [NCORES];
  logic [AW-1:0]     lane_addr [NCORES];
  logic [DW-1:0]     lane_data [NCORES];
  logic [CW-1:0]     win;
  logic              any;

  for (genvar c = 0; c < NCORES; c++) begin : g_lane
    tso_sb_lane #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (core_wr_valid[c]),
      .rd_valid  (core_rd_valid[c]),
      .flush     (core_flush[c]),
      .addr      (core_addr[c*AW +: AW]),
      .wdata     (core_wdata[c*DW +: DW]),
      .grant     (lane_gnt[c]),
      .wr_ready  (core_wr_ready[c]),
      .drained   (core_drained[c]),
      .rd_done   (core_rd_ack[c]),
      .req_valid (lane_req[c]),
      .req_kind  (lane_kind[c]),
      .req_addr  (lane_addr[c]),
      .req_data  (lane_data[c])
    );
  end

  tso_sb_rr #(.N(NCORES), .CW(CW)) i_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lane_req),
    .ready (pkt_ready),
    .any   (any),
    .win   (win),
    .gnt   (lane_gnt)
  );

  always_comb begin
    pkt_valid = any;
    pkt_core  = win;
    pkt_write = (lane_kind[win] == PKT_WR);
    pkt_addr  = lane_addr[win];
    pkt_data  = lane_data[win];
  end
endmodule

// File: rtl/tso_sbuf_chk.sv
module tso_sbuf_chk #(
  parameter int NCORES = 4,
  parameter int AW     = 32,
  parameter int CW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] core_rd_valid,
  input logic [NCORES-1:0] core_flush,
  input logic [NCORES-1:0] core_wr_ready,
  input logic [NCORES-1:0] core_rd_ack,
  input logic [NCORES-1:0] core_drained,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic              pkt_write,
  input logic [AW-1:0]     pkt_addr,
  input logic [CW-1:0]     pkt_core
);
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr) && $stable(pkt_write) && $stable(pkt_core)); // R9
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_rd_ack)); // R3
  AST_ACK_ON_READ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_rd_ack) |-> pkt_valid && pkt_ready && !pkt_write); // R3
  AST_WRITE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_write |-> !core_drained[pkt_core]); // R4

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    AST_READ_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      core_rd_valid[c] |-> !core_wr_ready[c]); // R10
    AST_FLUSH_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      core_flush[c] |-> !core_wr_ready[c]); // R7
  end
endmodule

bind tso_sbuf tso_sbuf_chk #(.NCORES(NCORES), .AW(AW), .CW(CW)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_rd_valid (core_rd_valid),
  .core_flush    (core_flush),
  .core_wr_ready (core_wr_ready),
  .core_rd_ack   (core_rd_ack),
  .core_drained  (core_drained),
  .pkt_valid     (pkt_valid),
  .pkt_ready     (pkt_ready),
  .pkt_write     (pkt_write),
  .pkt_addr      (pkt_addr),
  .pkt_core      (pkt_core)
);

// File: tb/test_tso_sbuf.sv
module test_tso_sbuf;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] wr_v = '0, rd_v = '0, fl = '0;
  logic [NC*32-1:0] addr_i = '0, wdata_i = '0;
  logic [NC-1:0] wr_rdy, rd_ack, drained;
  logic          pkt_valid, pkt_ready = 1'b1, pkt_write;
  logic [31:0]   pkt_addr, pkt_data;
  logic [1:0]    pkt_core;

  tso_sbuf #(.NCORES(NC), .DEPTH(D), .AW(32), .DW(32)) i_tso_sbuf (
    .clk(clk), .rst_n(rst_n),
    .core_wr_valid(wr_v), .core_rd_valid(rd_v), .core_flush(fl),
    .core_addr(addr_i), .core_wdata(wdata_i),
    .core_wr_ready(wr_rdy), .core_rd_ack(rd_ack), .core_drained(drained),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_write(pkt_write),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .pkt_core(pkt_core)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, pkt_cnt = 0;
  string cur_req = "R1";
  bit stall_on = 0;

  // behavioural reference
  logic [31:0] qa [NC][$];
  logic [31:0] qd [NC][$];
  bit m_pend [NC];
  int m_ptr = 0, m_lidx = 0;
  bit m_lock = 0;
  bit e_rv [NC], e_rw [NC], e_wrdy [NC], e_ack [NC], e_dr [NC], e_fl [NC];
  logic [31:0] e_ra [NC], e_rd [NC];
  bit e_valid;
  int e_win;

  function automatic void model_eval();
    for (int c = 0; c < NC; c++) begin
      bit hit = 0;
      logic [31:0] a = addr_i[c*32 +: 32];
      e_fl[c] = m_pend[c] || fl[c];
      e_rv[c] = 0; e_rw[c] = 0; e_ra[c] = 0; e_rd[c] = 0;
      foreach (qa[c][k]) if (qa[c][k] == a) hit = 1;
      if (rd_v[c]) begin
        e_rv[c] = 1;
        if (hit) begin e_rw[c] = 1; e_ra[c] = qa[c][0]; e_rd[c] = qd[c][0]; end
        else e_ra[c] = a;
      end else if ((e_fl[c] || (wr_v[c] && qa[c].size() == D)) && qa[c].size() > 0) begin
        e_rv[c] = 1; e_rw[c] = 1; e_ra[c] = qa[c][0]; e_rd[c] = qd[c][0];
      end
      e_wrdy[c] = !rd_v[c] && !e_fl[c] && qa[c].size() < D;
      e_dr[c] = (qa[c].size() == 0);
    end
    e_valid = 0;
    e_win = m_ptr;
    if (m_lock && e_rv[m_lidx]) begin e_valid = 1; e_win = m_lidx; end
    else begin
      for (int i = 0; i < NC; i++) begin
        int k = (m_ptr + i) % NC;
        if (!e_valid && e_rv[k]) begin e_valid = 1; e_win = k; end
      end
    end
    for (int c = 0; c < NC; c++)
      e_ack[c] = e_valid && pkt_ready && e_win == c && !e_rw[c];
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual=%h expected=%h", cur_req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin qa[c].delete(); qd[c].delete(); m_pend[c] = 0; end
      m_ptr = 0; m_lock = 0; m_lidx = 0;
    end else begin
      model_eval();
      if (e_valid && pkt_ready) begin
        pkt_cnt++;
        if (e_rw[e_win]) begin void'(qa[e_win].pop_front()); void'(qd[e_win].pop_front()); end
        m_ptr = (e_win + 1) % NC;
        m_lock = 0;
      end else if (e_valid) begin
        m_lock = 1; m_lidx = e_win;
      end
      for (int c = 0; c < NC; c++) begin
        if (wr_v[c] && e_wrdy[c]) begin
          qa[c].push_back(addr_i[c*32 +: 32]);
          qd[c].push_back(wdata_i[c*32 +: 32]);
        end
        m_pend[c] = e_fl[c] && qa[c].size() > 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      model_eval();
      chk("pkt_valid", 32'(pkt_valid), 32'(e_valid));
      if (e_valid) begin
        chk("pkt_core", 32'(pkt_core), 32'(e_win));
        chk("pkt_write", 32'(pkt_write), 32'(e_rw[e_win]));
        chk("pkt_addr", pkt_addr, e_ra[e_win]);
        chk("pkt_data", pkt_data, e_rd[e_win]);
      end
      for (int c = 0; c < NC; c++) begin
        chk("wr_ready", 32'(wr_rdy[c]), 32'(e_wrdy[c]));
        chk("rd_ack", 32'(rd_ack[c]), 32'(e_ack[c]));
        chk("drained", 32'(drained[c]), 32'(e_dr[c]));
      end
    end
  end

  task automatic do_write(input int c, input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_v[c] = 1; addr_i[c*32 +: 32] = a; wdata_i[c*32 +: 32] = d;
    do @(negedge clk); while (!wr_rdy[c]);
    @(posedge clk); #1;
    wr_v[c] = 0;
  endtask

  task automatic do_read(input int c, input logic [31:0] a);
    @(posedge clk); #1;
    rd_v[c] = 1; addr_i[c*32 +: 32] = a;
    do @(negedge clk); while (!rd_ack[c]);
    @(posedge clk); #1;
    rd_v[c] = 0;
  endtask

  task automatic do_flush(input int c);
    @(posedge clk); #1;
    fl[c] = 1;
    @(posedge clk); #1;
    fl[c] = 0;
    do @(negedge clk); while (!drained[c]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    fork
      forever begin
        @(posedge clk); #1;
        pkt_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
      end
    join_none
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset pkt_valid", 32'(pkt_valid), 0);
    chk("reset drained", 32'(drained), 32'hF);
    chk("reset wr_ready", 32'(wr_rdy), 32'hF);
    chk("reset rd_ack", 32'(rd_ack), 0);

    cur_req = "R2";
    base = pkt_cnt;
    do_write(0, 32'h100, 32'h11);
    do_write(0, 32'h104, 32'h22);
    do_write(0, 32'h108, 32'h33);
    @(negedge clk);
    chk("R2 packets from stores", 32'(pkt_cnt - base), 0);
    chk("R2 not drained", 32'(drained[0]), 0);

    cur_req = "R3";
    base = pkt_cnt;
    do_read(0, 32'h200);
    chk("R3 read miss packets", 32'(pkt_cnt - base), 1);

    cur_req = "R4";
    do_write(0, 32'h100, 32'h44);
    base = pkt_cnt;
    do_read(0, 32'h104);
    chk("R4 drain through match", 32'(pkt_cnt - base), 3);
    chk("R4 younger kept", 32'(drained[0]), 0);
    cur_req = "R5";
    base = pkt_cnt;
    do_read(0, 32'h100);
    chk("R5 youngest match drain", 32'(pkt_cnt - base), 3);
    @(negedge clk);
    chk("R5 empty after", 32'(drained[0]), 1);

    cur_req = "R6";
    for (int i = 0; i < D; i++) do_write(1, 32'h300 + 32'(i*4), 32'h50 + 32'(i));
    base = pkt_cnt;
    do_write(1, 32'h400, 32'h99);
    chk("R6 full store drains one", 32'(pkt_cnt - base), 1);

    cur_req = "R7";
    base = pkt_cnt;
    do_flush(1);
    chk("R7 flush drains all", 32'(pkt_cnt - base), D);
    do_flush(1);
    chk("R7 empty flush no packet", 32'(pkt_cnt - base), D);

    cur_req = "R8";
    stall_on = 1;
    do_write(2, 32'h500, 32'h77);
    base = pkt_cnt;
    fork
      do_read(0, 32'h600);
      do_read(1, 32'h604);
      do_read(2, 32'h500);
      do_read(3, 32'h608);
    join
    chk("R8 contention packets", 32'(pkt_cnt - base), 5);
    cur_req = "R9";
    fork
      do_read(3, 32'h700);
      do_read(1, 32'h704);
    join

    cur_req = "R10";
    stall_on = 0;
    do_write(2, 32'h800, 32'h12);
    @(posedge clk); #1;
    wr_v[2] = 1; rd_v[2] = 1; addr_i[64 +: 32] = 32'h900; wdata_i[64 +: 32] = 32'h34;
    @(negedge clk);
    chk("R10 store held by read", 32'(wr_rdy[2]), 0);
    chk("R10 read issued", 32'(rd_ack[2]), 1);
    @(posedge clk); #1;
    rd_v[2] = 0;
    do @(negedge clk); while (!wr_rdy[2]);
    @(posedge clk); #1;
    wr_v[2] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule